// File: doc/BRIEF.md
# Masked GPIO port register bank

This block is the register front end of one 29-pin general-purpose I/O port. A word-wide register bus with an address, a write strobe, write data and read data gives software access to the pins. Writes take effect on the clock edge that samples the strobe. Read data is a combinational function of the address and of the current state.

Each pin has its own word register. That register reads as all-zeros or all-ones and sets or clears the pin's output bit. A direction register drives the pad output enables. A plain port register reads and loads all pins at once. A masked port register does the same, but only for the pins whose mask bit is clear. Pad inputs pass through two synchronizer flops before any read path sees them. An analog-mode vector forces the affected pins to read as zero in every read path.

Top module: `gpio_port_bank`

Register map, byte offsets, word aligned:
- per-pin word register for pin i: 4*i, for i = 0..28 (0x000 to 0x070)
- DIR: 0x100
- MASK: 0x104
- PORT, unmasked: 0x108
- MPORT, masked: 0x10C

## Requirements
- R1: DIR and MASK keep only bits 28:0. Bits 31:29 read as 0, and writing them has no effect.
- R2: A read of a pin's word register returns 0x00000000 when the synchronized pin level is low and 0xFFFFFFFF when it is high, and no other value.
- R3: A write of 0 to the word register of pin i clears pad_out[i]. A write of any nonzero value sets it. No other output bit changes.
- R4: A DIR bit of 1 makes that pin an output and 0 makes it an input. pad_oe equals DIR, and DIR resets to 0.
- R5: A write to MPORT loads pad_out[i] from write data bit i only where MASK bit i is 0. Where MASK bit i is 1, pad_out[i] keeps its value.
- R6: A read of MPORT returns the pin levels, with 0 in every position whose MASK bit is 1 and in bits 31:29.
- R7: A write to PORT loads all 29 output bits from write data bits 28:0, whatever MASK holds. A read of PORT returns the pin levels, whatever DIR and MASK hold.
- R8: A pin whose pad_analog bit is 1 reads as 0 through its word register, PORT and MPORT.
- R9: A change on pad_in first appears in read data after the second rising clock edge that follows it.
- R10: After reset, pad_out, DIR and MASK are 0. A read of any unmapped or unaligned address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address of the register |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_in | input | 29 | Raw pad input levels |
| pad_analog | input | 29 | Per-pin analog mode; a 1 forces reads of that pin to 0 |
| pad_out | output | 29 | Output bit per pin |
| pad_oe | output | 29 | Output enable per pin, 1 = drive |

## Verification
A wrong mask bit appears on the first MPORT access after it. On a write, an output bit changes that should have held, or holds when it should have changed. On a read, a bit comes back that should read as 0, or a 0 comes back in a position that should be live. A corrupted output bit shows on pad_out on the cycle after the write that caused it. A synchronizer that is too short or too long shifts by one edge the read at which a new pad level first appears. Wrong decoding of a word register shows as a neighbour's output bit changing, or as read data that is neither all-zeros nor all-ones.

// File: rtl/gpio_port_bank.sv
module gpio_port_bank #(
  parameter int NPIN = 29,
  parameter int AW   = 12,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NPIN-1:0] pad_in,
  input  logic [NPIN-1:0] pad_analog,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe
);
  localparam int IW = $clog2(NPIN);
  localparam logic [AW-1:0] A_DIR   = AW'('h100);
  localparam logic [AW-1:0] A_MASK  = AW'('h104);
  localparam logic [AW-1:0] A_PORT  = AW'('h108);
  localparam logic [AW-1:0] A_MPORT = AW'('h10C);
  localparam logic [AW-3:0] NWORDS  = (AW-2)'(NPIN);

  logic [NPIN-1:0] dir_q, mask_q, out_q, sync1_q, sync2_q, lvl;
  logic            word_hit;
  logic [IW-1:0]   word_idx;

  assign word_hit = (bus_addr[1:0] == 2'b00) && (bus_addr[AW-1:2] < NWORDS);
  assign word_idx = bus_addr[IW+1:2];
  assign lvl      = sync2_q & ~pad_analog;
  assign pad_out  = out_q;
  assign pad_oe   = dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      mask_q <= '0;
      out_q  <= '0;
    end else if (bus_we) begin
      if (word_hit) begin
        out_q[word_idx] <= |bus_wdata;
      end else begin
        case (bus_addr)
          A_DIR:   dir_q  <= bus_wdata[NPIN-1:0];
          A_MASK:  mask_q <= bus_wdata[NPIN-1:0];
          A_PORT:  out_q  <= bus_wdata[NPIN-1:0];
          A_MPORT: out_q  <= (out_q & mask_q) | (bus_wdata[NPIN-1:0] & ~mask_q);
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (word_hit) begin
      bus_rdata = {DW{lvl[word_idx]}};
    end else begin
      case (bus_addr)
        A_DIR:   bus_rdata = {{(DW-NPIN){1'b0}}, dir_q};
        A_MASK:  bus_rdata = {{(DW-NPIN){1'b0}}, mask_q};
        A_PORT:  bus_rdata = {{(DW-NPIN){1'b0}}, lvl};
        A_MPORT: bus_rdata = {{(DW-NPIN){1'b0}}, lvl & ~mask_q};
        default: bus_rdata = '0;
      endcase
    end
  end

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_addr == A_DIR) || (bus_addr == A_MASK)) |-> (bus_rdata[DW-1:NPIN] == '0));

  a_r2_word_read_solid: assert property (@(posedge clk) disable iff (!rst_n)
    word_hit |-> ((bus_rdata == '0) || (bus_rdata == '1)));

  a_r3_word_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && word_hit) |=> (pad_out[$past(word_idx)] == $past(|bus_wdata)));

  a_r4_oe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && (bus_addr == A_DIR)) |=> $stable(pad_oe));

  a_r5_mport_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr == A_MPORT)) |=> (((pad_out ^ $past(pad_out)) & $past(mask_q)) == '0));

  a_r7_port_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr == A_PORT)) |=> (pad_out == $past(bus_wdata[NPIN-1:0])));

  a_r8_analog_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (word_hit && pad_analog[word_idx]) |-> (bus_rdata == '0));

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_hit && (bus_addr != A_DIR) && (bus_addr != A_MASK) &&
     (bus_addr != A_PORT) && (bus_addr != A_MPORT)) |-> (bus_rdata == '0));
endmodule

// File: tb/test_gpio_port_bank.sv
module test_gpio_port_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 21;
  // entry: {req[3:0], kind[1:0], addr[11:0], data[31:0], exp[31:0]}
  // kind 0: write, then check pad_out; 1: read, check rdata; 2: write, then check pad_oe
  localparam logic [81:0] VEC [0:NV-1] = '{
    {4'd7,  2'd0, 12'h108, 32'hFFFF_FFFF, 32'h1FFF_FFFF}, // R7 PORT load
    {4'd1,  2'd0, 12'h104, 32'hFFFF_0000, 32'h1FFF_FFFF}, // R1 MASK write
    {4'd1,  2'd1, 12'h104, 32'h0,         32'h1FFF_0000}, // R1 reserved bits zero
    {4'd5,  2'd0, 12'h10C, 32'h0,         32'h1FFF_0000}, // R5 masked bits hold
    {4'd6,  2'd1, 12'h10C, 32'h0,         32'h0000_5678}, // R6 masked read
    {4'd7,  2'd1, 12'h108, 32'h0,         32'h1234_5678}, // R7 read ignores mask
    {4'd7,  2'd0, 12'h108, 32'h0000_00F0, 32'h0000_00F0}, // R7 write ignores mask
    {4'd3,  2'd0, 12'h00C, 32'h8000_0000, 32'h0000_00F8}, // R3 nonzero sets
    {4'd3,  2'd0, 12'h014, 32'h0,         32'h0000_00D8}, // R3 zero clears
    {4'd2,  2'd1, 12'h00C, 32'h0,         32'hFFFF_FFFF}, // R2 high
    {4'd2,  2'd1, 12'h000, 32'h0,         32'h0000_0000}, // R2 low
    {4'd4,  2'd2, 12'h100, 32'hFFFF_FFFF, 32'h1FFF_FFFF}, // R4 oe follows DIR
    {4'd1,  2'd1, 12'h100, 32'h0,         32'h1FFF_FFFF}, // R1 DIR reserved
    {4'd7,  2'd1, 12'h108, 32'h0,         32'h1234_5678}, // R7 read ignores DIR
    {4'd4,  2'd2, 12'h100, 32'h0000_0005, 32'h0000_0005}, // R4 partial DIR
    {4'd10, 2'd1, 12'h110, 32'h0,         32'h0},         // R10 unmapped
    {4'd10, 2'd1, 12'h074, 32'h0,         32'h0},         // R10 past last pin
    {4'd10, 2'd1, 12'h00D, 32'h0,         32'h0},         // R10 unaligned
    {4'd3,  2'd0, 12'h070, 32'h0000_0001, 32'h1000_00D8}, // R3 last pin
    {4'd5,  2'd0, 12'h104, 32'h0,         32'h1000_00D8}, // R5 clear mask
    {4'd5,  2'd0, 12'h10C, 32'h0000_FFFF, 32'h0000_FFFF}  // R5 all through
  };

  logic        clk = 0, rst_n = 0, bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [28:0] pad_in = '0, pad_analog = '0, pad_out, pad_oe;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  gpio_port_bank i_gpio_port_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_analog(pad_analog), .pad_out(pad_out), .pad_oe(pad_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
    #1;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    logic [31:0] r;
    #(3*CLK_PERIOD) rst_n = 1;
    // R10 reset state, R4 inputs after reset
    #1;
    check(10, {3'b0, pad_out}, 32'h0);
    check(4, {3'b0, pad_oe}, 32'h0);
    rd(12'h100, r); check(10, r, 32'h0);
    rd(12'h104, r); check(10, r, 32'h0);

    pad_in = 29'h1234_5678;
    repeat (3) @(negedge clk);
    for (int k = 0; k < NV; k++) begin
      logic [81:0] e;
      e = VEC[k];
      if (e[77:76] == 2'd1) begin
        rd(e[75:64], r);
        check(int'(e[81:78]), r, e[31:0]);
      end else begin
        wr(e[75:64], e[63:32]);
        check(int'(e[81:78]), (e[77:76] == 2'd2) ? {3'b0, pad_oe} : {3'b0, pad_out}, e[31:0]);
      end
    end

    // R9: new level after exactly two edges
    @(negedge clk);
    bus_addr = 12'h108;
    pad_in = 29'h0ABC_DEF0;
    @(negedge clk); #1 check(9, bus_rdata, 32'h1234_5678);
    @(negedge clk); #1 check(9, bus_rdata, 32'h0ABC_DEF0);

    // R8: analog pin 4 (level high) reads as 0 everywhere
    pad_analog = 29'h0000_0010;
    rd(12'h010, r); check(8, r, 32'h0);
    rd(12'h108, r); check(8, r, 32'h0ABC_DEE0);
    wr(12'h104, 32'h0);
    rd(12'h10C, r); check(8, r, 32'h0ABC_DEE0);
    pad_analog = '0;
    rd(12'h010, r); check(2, r, 32'hFFFF_FFFF);

    // R5/R6 partial mask: alternate bits masked
    wr(12'h108, 32'h0);
    wr(12'h104, 32'h1555_5555);
    wr(12'h10C, 32'hFFFF_FFFF);
    check(5, {3'b0, pad_out}, 32'h0AAA_AAAA);
    rd(12'h10C, r); check(6, r, 32'h0ABC_DEF0 & 32'h0AAA_AAAA);
    rd(12'h104, r); check(1, r, 32'h1555_5555);

    // R10: reset returns everything to 0
    @(negedge clk); rst_n = 0; #1;
    check(10, {3'b0, pad_out}, 32'h0);
    @(negedge clk); rst_n = 1;
    rd(12'h104, r); check(10, r, 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule